// File: doc/BRIEF.md
# Trigger Retiming and Deterministic Marker

This block takes a trigger input with no timing relation to the sample clock, such as an external strobe, a once-per-second pulse or a frame pulse. It moves that trigger into the sample clock domain through a synchronizer of fixed depth. A rising edge of the retimed trigger then becomes a one-cycle marker, generated only by sample-domain logic. Because the synchronizer and edge stage never change, the delay from the capturing clock edge to the marker is always the same number of cycles. The block drives that number on a constant output port, so acceptance tests can read it and compare it with what they measure.

A free-running sample index acts as the time tag for the stream. When a marker fires, the block latches the index of that marker cycle so it can be read afterwards. Arming is always a fixed sequence. An arm request first raises a one-cycle clear strobe for the downstream buffers and pipeline stages. The block then waits for a block boundary, meaning an index that is a whole multiple of the block length, and only then starts accepting triggers. One marker disarms the block. Any trigger edges that arrive after that are not used but are counted, until software arms the block again.

Top module: `trm_marker_top`

## Requirements
- R1: After reset, marker, armed and stage_clr are 0, missed_cnt is 0, and trig_to_mark_ofs reads SYNC_STAGES+1 (3 with default parameters).
- R2: sample_idx starts at 0 after reset and increases by exactly 1 on every clock cycle.
- R3: In the cycle after an arm_req pulse, stage_clr is high for exactly one cycle, and armed is low in that cycle.
- R4: armed first rises in the cycle whose sample_idx is the smallest multiple of BLK_LEN that is at least two greater than the sample_idx of the stage_clr cycle.
- R5: If a rising edge of trig_async, set up before clock edge k, arrives while the block is armed, marker is high only in the cycle after edge k+2. That is exactly trig_to_mark_ofs cycles after capture.
- R6: During every marker cycle, marker_tag equals sample_idx, and marker_tag holds that value until the next marker.
- R7: marker is never high for two consecutive cycles. A marker is only produced if armed was high in the previous cycle, and armed is low from the marker cycle on.
- R8: Every trigger rising edge seen after a marker and before the next arm_req adds one to missed_cnt. The count saturates at its maximum and is never reset by arming.
- R9: Trigger edges seen before the first arming, or while the block is waiting for a boundary, produce no marker and do not change missed_cnt.
- R10: A trigger that is already high when arming completes produces no marker. Only a new rising edge fires.
- R11: Repeated arm-and-fire cycles, started at different index phases, always measure the same trigger-to-marker offset, equal to trig_to_mark_ofs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_async | input | 1 | Trigger level, asynchronous to clk |
| arm_req | input | 1 | One-cycle request to start the clear-then-arm sequence |
| sample_idx | output | IDX_W (48) | Free-running sample time tag |
| marker | output | 1 | One-cycle marker for the accepted trigger |
| armed | output | 1 | High while the block accepts a trigger |
| stage_clr | output | 1 | One-cycle clear strobe to downstream buffers and stages |
| marker_tag | output | IDX_W (48) | Sample index latched in the last marker cycle |
| missed_cnt | output | MISS_W (16) | Saturating count of trigger edges after a marker |
| trig_to_mark_ofs | output | 8 | Fixed number of cycles from trigger capture to marker |

## Verification
The hardest thing to show from the ports is that arming is tied to the block boundary and not to the time of the request. This is only visible when the request lands at different index phases, including phases one or two cycles before a boundary, where a design that arms too early passes by chance. The stimulus therefore repeats the arm-and-fire sequence with a different delay before each request. For each run it computes the expected boundary from the index seen in the clear cycle, then measures the trigger-to-marker offset again. A trigger held high across arming, and edges arriving after the marker, show that only a fresh edge in the armed window fires a marker and that late edges are counted and never fire.

// File: rtl/trm_pkg.sv
package trm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_WAIT  = 3'd2,
        ST_ARMED = 3'd3,
        ST_FIRED = 3'd4
    } arm_st_e;
endpackage

// File: rtl/trm_sync.sv
module trm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/trm_timebase.sv
module trm_timebase #(
    parameter int IDX_W   = 48,
    parameter int BLK_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] idx_next,
    output logic             boundary_next
);
    localparam int BLK_W = $clog2(BLK_LEN);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx           = idx_q;
    assign idx_next      = idx_d;
    assign boundary_next = (idx_d[BLK_W-1:0] == '0);
endmodule

// File: rtl/trm_arm_fsm.sv
module trm_arm_fsm
    import trm_pkg::*;
#(
    parameter int IDX_W  = 48,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_req,
    input  logic              rise,
    input  logic              boundary_next,
    input  logic [IDX_W-1:0]  idx_next,
    output logic              marker,
    output logic              armed,
    output logic              stage_clr,
    output logic [IDX_W-1:0]  tag,
    output logic [MISS_W-1:0] miss
);
    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    typedef struct packed {
        arm_st_e           st;
        logic              marker;
        logic [IDX_W-1:0]  tag;
        logic [MISS_W-1:0] miss;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.marker = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (arm_req) r_d.st = ST_CLEAR;
            end
            ST_CLEAR: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (arm_req)            r_d.st = ST_CLEAR;
                else if (boundary_next) r_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (arm_req) begin
                    r_d.st = ST_CLEAR;
                end else if (rise) begin
                    r_d.st     = ST_FIRED;
                    r_d.marker = 1'b1;
                    r_d.tag    = idx_next;
                end
            end
            ST_FIRED: begin
                if (arm_req) begin
                    r_d.st = ST_CLEAR;
                end else if (rise && (r_q.miss != MISS_MAX)) begin
                    r_d.miss = r_q.miss + MISS_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.marker <= 1'b0;
            r_q.tag    <= '0;
            r_q.miss   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign marker    = r_q.marker;
    assign armed     = (r_q.st == ST_ARMED);
    assign stage_clr = (r_q.st == ST_CLEAR);
    assign tag       = r_q.tag;
    assign miss      = r_q.miss;
endmodule

// File: rtl/trm_marker_top.sv
module trm_marker_top #(
    parameter int IDX_W       = 48,
    parameter int BLK_LEN     = 16,
    parameter int MISS_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_async,
    input  logic              arm_req,
    output logic [IDX_W-1:0]  sample_idx,
    output logic              marker,
    output logic              armed,
    output logic              stage_clr,
    output logic [IDX_W-1:0]  marker_tag,
    output logic [MISS_W-1:0] missed_cnt,
    output logic [7:0]        trig_to_mark_ofs
);
    // synchronizer stages plus the registered marker stage
    localparam int OFS_CYC = SYNC_STAGES + 1;

    logic             rise;
    logic             bnd_next;
    logic [IDX_W-1:0] idx_nx;

    trm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_async),
        .rise     (rise)
    );

    trm_timebase #(.IDX_W(IDX_W), .BLK_LEN(BLK_LEN)) u_tb (
        .clk           (clk),
        .rst_n         (rst_n),
        .idx           (sample_idx),
        .idx_next      (idx_nx),
        .boundary_next (bnd_next)
    );

    trm_arm_fsm #(.IDX_W(IDX_W), .MISS_W(MISS_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_req       (arm_req),
        .rise          (rise),
        .boundary_next (bnd_next),
        .idx_next      (idx_nx),
        .marker        (marker),
        .armed         (armed),
        .stage_clr     (stage_clr),
        .tag           (marker_tag),
        .miss          (missed_cnt)
    );

    assign trig_to_mark_ofs = 8'(OFS_CYC);
endmodule

// File: rtl/trm_checker.sv
module trm_checker #(
    parameter int IDX_W   = 48,
    parameter int BLK_LEN = 16,
    parameter int MISS_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  sample_idx,
    input logic              marker,
    input logic              armed,
    input logic              stage_clr,
    input logic [IDX_W-1:0]  marker_tag,
    input logic [MISS_W-1:0] missed_cnt
);
    localparam int BLK_W = $clog2(BLK_LEN);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> sample_idx == $past(sample_idx) + IDX_W'(1));

    a_r3_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stage_clr |=> (!stage_clr && !armed));

    a_r4_arm_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && armed && !$past(armed)) |-> sample_idx[BLK_W-1:0] == '0);

    a_r6_tag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        marker |-> marker_tag == sample_idx);

    a_r7_single_marker: assert property (@(posedge clk) disable iff (!rst_n)
        marker |=> !marker);

    a_r7_marker_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && marker) |-> ($past(armed) && !armed));

    a_r8_miss_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> missed_cnt >= $past(missed_cnt));
endmodule

bind trm_marker_top trm_checker #(
    .IDX_W(IDX_W), .BLK_LEN(BLK_LEN), .MISS_W(MISS_W)
) u_trm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_idx (sample_idx),
    .marker     (marker),
    .armed      (armed),
    .stage_clr  (stage_clr),
    .marker_tag (marker_tag),
    .missed_cnt (missed_cnt)
);

// File: tb/trm_marker_top_bench.sv
module trm_marker_top_bench;
    localparam int IDX_W = 48;
    localparam int BLK   = 16;
    localparam int MW    = 16;
    localparam int OFS   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_async = 1'b0;
    logic             arm_req = 1'b0;
    logic [IDX_W-1:0] sample_idx;
    logic             marker;
    logic             armed;
    logic             stage_clr;
    logic [IDX_W-1:0] marker_tag;
    logic [MW-1:0]    missed_cnt;
    logic [7:0]       trig_to_mark_ofs;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    trm_marker_top u_trm_marker_top (
        .clk(clk), .rst_n(rst_n), .trig_async(trig_async), .arm_req(arm_req),
        .sample_idx(sample_idx), .marker(marker), .armed(armed),
        .stage_clr(stage_clr), .marker_tag(marker_tag),
        .missed_cnt(missed_cnt), .trig_to_mark_ofs(trig_to_mark_ofs)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    // R1 reset state and R2 index counting
    task automatic t_reset();
        longint prev;
        chk(marker == 0 && armed == 0 && stage_clr == 0, "R1", {marker, armed, stage_clr}, 0);
        chk(missed_cnt == 0, "R1", missed_cnt, 0);
        chk(trig_to_mark_ofs == OFS, "R1", trig_to_mark_ofs, OFS);
        chk(sample_idx == 1, "R2", sample_idx, 1);
        prev = sample_idx;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(sample_idx == prev + 1, "R2", sample_idx, prev + 1);
            prev = sample_idx;
        end
    endtask

    // R9: edges before any arming are neither marked nor counted
    task automatic t_idle_trigger();
        for (int i = 0; i < 2; i++) begin
            trig_async = 1'b1; repeat (3) @(negedge clk);
            trig_async = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(missed_cnt == 0, "R9", missed_cnt, 0);
        chk(marker_tag == 0, "R9", marker_tag, 0);
    endtask

    // R3, R4: clear strobe then arm on the first allowed boundary
    task automatic t_arm();
        longint c, exp_idx;
        int guard = 0;
        arm_req = 1'b1;
        @(negedge clk);
        arm_req = 1'b0;
        chk(stage_clr == 1 && armed == 0, "R3", {stage_clr, armed}, 2);
        c = sample_idx;
        @(negedge clk);
        chk(stage_clr == 0, "R3", stage_clr, 0);
        exp_idx = ((c + 2 + BLK - 1) / BLK) * BLK;
        while (!armed && guard < 4 * BLK) begin
            @(negedge clk);
            guard++;
        end
        chk(sample_idx == exp_idx, "R4", sample_idx, exp_idx);
    endtask

    // R5, R6, R7: fire and measure the offset; returns measured cycles
    task automatic t_fire(output int meas);
        longint i0;
        meas = -1;
        trig_async = 1'b1;
        i0 = sample_idx;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (marker && meas < 0) begin
                meas = k;
                chk(marker_tag == i0 + OFS, "R6", marker_tag, i0 + OFS);
                chk(armed == 0, "R7", armed, 0);
            end else if (marker) begin
                chk(0, "R7", 1, 0);
            end
        end
        chk(meas == OFS, "R5", meas, OFS);
        chk(marker_tag == i0 + OFS, "R6", marker_tag, i0 + OFS);
        trig_async = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R8: edges after the marker are counted, never marked
    task automatic t_after_fire();
        longint m0 = missed_cnt;
        longint tg = marker_tag;
        bit saw = 0;
        for (int i = 0; i < 3; i++) begin
            trig_async = 1'b1;
            repeat (3) begin @(negedge clk); saw |= marker; end
            trig_async = 1'b0;
            repeat (3) begin @(negedge clk); saw |= marker; end
        end
        chk(!saw, "R8", saw, 0);
        chk(missed_cnt == m0 + 3, "R8", missed_cnt, m0 + 3);
        chk(marker_tag == tg, "R6", marker_tag, tg);
    endtask

    // R10: trigger already high through arming must not fire
    task automatic t_held_high();
        bit saw = 0;
        int meas;
        trig_async = 1'b1;
        repeat (4) @(negedge clk);
        t_arm();
        repeat (8) begin @(negedge clk); saw |= marker; end
        chk(!saw && armed, "R10", saw, 0);
        trig_async = 1'b0;
        repeat (3) @(negedge clk);
        t_fire(meas);
    endtask

    // R9: edge during the boundary wait is ignored and not counted
    task automatic t_wait_trigger();
        longint m0 = missed_cnt;
        bit saw = 0;
        while (sample_idx % BLK != 3) @(negedge clk);
        arm_req = 1'b1; @(negedge clk); arm_req = 1'b0;
        trig_async = 1'b1;
        repeat (4) begin @(negedge clk); saw |= marker; end
        trig_async = 1'b0;
        while (!armed) begin @(negedge clk); saw |= marker; end
        chk(!saw, "R9", saw, 0);
        chk(missed_cnt == m0, "R9", missed_cnt, m0);
    endtask

    // R11: offset repeats across re-arms at different phases
    task automatic t_repeat();
        int meas;
        for (int i = 0; i < 5; i++) begin
            repeat (i * 5 + 1) @(negedge clk);
            t_arm();
            repeat (i) @(negedge clk);
            t_fire(meas);
            chk(meas == trig_to_mark_ofs, "R11", meas, trig_to_mark_ofs);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_trigger();
        t_arm();
        begin int m; t_fire(m); end
        t_after_fire();
        t_held_high();
        t_wait_trigger();
        begin int m; t_fire(m); end
        t_repeat();
        summary();
    end
endmodule